// File: doc/BRIEF.md
# Multi-Tag Reply Buffer Distributor

This block gathers 32-bit reply words from a host processor and turns them into per-tag 64-bit serial streams. The host writes two words per responding tag, one after the other, into a small word store. When every responding tag has been written, the host pulses a completion strobe. The block then reads the store back pair by pair, copies each pair into the matching channel's 64-bit shift register, and shifts every loaded channel out one bit at a time. The bit pace comes from a slow enable, either the lower or the double bit rate.

Each channel drives a serial bit and a bit strobe toward its encoder. A channel that received no pair stays silent. The block reports how many tags responded, computed from the number of complete pairs read back. A single done pulse marks the end of the 64th bit, and the block is then ready for the next batch. A tag with nothing to send in its second word is handled by the host writing an all-zero filler word.

Top module: `reply_distributor`

## Requirements
- R1: In the cycle after reset, `busy`, `overflow`, `tx_done`, `resp_count`, `ch_valid`, `ch_stb` and `ch_bit` are all zero.
- R2: Each batch starts filling at slot 0. Word 2k and word 2k+1 of a batch, counted in write order, form the reply of channel k. Word 2k supplies reply bits [31:0] and word 2k+1 supplies bits [63:32].
- R3: A write is ignored, and `overflow` is high in the following cycle, in three cases: the block is busy, the store already holds 2*N_CH words, or `wr_done` is high in the same cycle.
- R4: Distribution begins only on `wr_done` while idle. `busy` is high from the cycle after that strobe until `tx_done`.
- R5: Every loaded channel emits 64 bits, least significant bit first, each marked by a one-cycle high on its `ch_stb` bit. A channel with no pair never strobes and holds `ch_bit` at 0.
- R6: Consecutive bit strobes are DIV_SLOW clock cycles apart when `rate_sel` was 0 at the completion strobe. They are DIV_FAST cycles apart when it was 1.
- R7: `resp_count` equals the number of complete word pairs in the batch, and any trailing odd word is dropped. `ch_valid` has exactly the low `resp_count` bits set. When idle, the number of set `ch_valid` bits always equals `resp_count`.
- R8: `tx_done` is a single-cycle pulse one cycle after the final bit strobe, and `busy` is already low in that cycle. With zero pairs, `tx_done` follows two cycles after the completion strobe and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host word write request |
| wr_data | input | WORD_W | Host reply word |
| wr_done | input | 1 | Host strobe: all tags have written |
| rate_sel | input | 1 | 0 selects the slow bit rate, 1 selects the fast bit rate; sampled at `wr_done` |
| busy | output | 1 | Distribution or shifting in progress |
| overflow | output | 1 | One-cycle flag for an ignored write |
| resp_count | output | $clog2(N_CH+1) | Number of tags that responded in the last batch |
| ch_valid | output | N_CH | Channel holds a reply in this batch |
| ch_bit | output | N_CH | Serial reply bit per channel |
| ch_stb | output | N_CH | Bit strobe per channel |
| tx_done | output | 1 | One-cycle pulse after the final bit |

## Verification
On every cycle, the bound assertions check several properties. Strobes and bits appear only on valid channels. A busy write always raises the overflow flag. Busy only rises after a completion strobe. The done pulse is one cycle long and falls outside busy. The count of valid channels matches the responder count whenever the block is idle. Other properties need whole batches and can only be shown by the bench's scenarios: the pair-to-channel mapping, LSB-first bit order, strobe spacing for each rate, dropping of a trailing odd word, and the absence of any trace from ignored writes in later batches.

// File: rtl/reply_dist_pkg.sv
package reply_dist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAIN,
    ST_SHIFT,
    ST_FINISH
  } dist_state_t;
endpackage

// File: rtl/reply_word_store.sv
module reply_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/reply_rate_gen.sv
module reply_rate_gen #(
  parameter int DIV_SLOW = 2500,
  parameter int DIV_FAST = 1250,
  localparam int DMAX    = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST,
  localparam int CW      = $clog2(DMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel_fast,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = sel_fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign tick   = run && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim_m1) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/reply_chan_shifter.sv
module reply_chan_shifter #(
  parameter int WORD_W  = 32,
  localparam int REPLY_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_en,
  input  logic              ld_hi,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              shift,
  output logic              valid_o,
  output logic              bit_o,
  output logic              stb_o
);
  logic [REPLY_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh      <= '0;
      valid_o <= 1'b0;
    end else if (ld_en) begin
      if (ld_hi) begin
        sh[REPLY_W-1:WORD_W] <= ld_word;
        valid_o              <= 1'b1;
      end else begin
        sh[WORD_W-1:0] <= ld_word;
      end
    end else if (shift) begin
      sh <= sh >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o <= 1'b0;
      stb_o <= 1'b0;
    end else if (shift) begin
      bit_o <= sh[0] & valid_o;
      stb_o <= valid_o;
    end else begin
      bit_o <= 1'b0;
      stb_o <= 1'b0;
    end
  end
endmodule

// File: rtl/reply_distributor.sv
module reply_distributor #(
  parameter int N_CH     = 4,
  parameter int WORD_W   = 32,
  parameter int DIV_SLOW = 2500,
  parameter int DIV_FAST = 1250,
  localparam int CW      = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              rate_sel,
  output logic              busy,
  output logic              overflow,
  output logic [CW-1:0]     resp_count,
  output logic [N_CH-1:0]   ch_valid,
  output logic [N_CH-1:0]   ch_bit,
  output logic [N_CH-1:0]   ch_stb,
  output logic              tx_done
);
  import reply_dist_pkg::*;

  localparam int DEPTH   = 2 * N_CH;
  localparam int AW      = $clog2(DEPTH);
  localparam int PW      = $clog2(DEPTH + 1);
  localparam int CHW     = AW - 1;
  localparam int REPLY_W = 2 * WORD_W;
  localparam int BW      = $clog2(REPLY_W);

  dist_state_t       state;
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     pair_words;
  logic [AW-1:0]     rd_addr;
  logic [AW-1:0]     last_rd;
  logic [AW-1:0]     ld_addr;
  logic              ld_v;
  logic              rd_en;
  logic [WORD_W-1:0] rd_word;
  logic [BW-1:0]     bit_cnt;
  logic              rate_q;
  logic              tick;
  logic              store_full;
  logic              accept_wr;
  logic              accept_done;
  logic              clr_ch;

  assign busy        = (state != ST_IDLE);
  assign store_full  = (wr_ptr == PW'(DEPTH));
  assign accept_done = (state == ST_IDLE) && wr_done;
  assign accept_wr   = wr_en && (state == ST_IDLE) && !wr_done && !store_full;
  assign pair_words  = {wr_ptr[PW-1:1], 1'b0};
  assign rd_en       = (state == ST_LOAD);
  assign clr_ch      = accept_done;

  reply_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .we   (accept_wr),
    .waddr(wr_ptr[AW-1:0]),
    .wdata(wr_data),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(rd_word)
  );

  reply_rate_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_SHIFT),
    .sel_fast(rate_q),
    .tick    (tick)
  );

  // Host-side write pointer and overflow flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= wr_en && (busy || wr_done || store_full);
      if (accept_done) wr_ptr <= '0;
      else if (accept_wr) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  // Distribution sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rd_addr <= '0;
      last_rd <= '0;
      rate_q  <= 1'b0;
      bit_cnt <= '0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (wr_done) begin
            rd_addr <= '0;
            last_rd <= AW'(pair_words - PW'(1));
            rate_q  <= rate_sel;
            bit_cnt <= '0;
            state   <= (pair_words != '0) ? ST_LOAD : ST_FINISH;
          end
        end
        ST_LOAD: begin
          rd_addr <= rd_addr + 1'b1;
          if (rd_addr == last_rd) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (tick) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BW'(REPLY_W - 1)) state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          tx_done <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read pipeline tag and responder count.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_v       <= 1'b0;
      ld_addr    <= '0;
      resp_count <= '0;
    end else begin
      ld_v    <= rd_en;
      ld_addr <= rd_addr;
      if (clr_ch) resp_count <= '0;
      else if (ld_v && ld_addr[0]) resp_count <= resp_count + 1'b1;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic sel_k;
    assign sel_k = ld_v && (ld_addr[AW-1:1] == CHW'(k));
    reply_chan_shifter #(.WORD_W(WORD_W)) u_sh (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_ch),
      .ld_en  (sel_k),
      .ld_hi  (ld_addr[0]),
      .ld_word(rd_word),
      .shift  (tick),
      .valid_o(ch_valid[k]),
      .bit_o  (ch_bit[k]),
      .stb_o  (ch_stb[k])
    );
  end
endmodule

// File: rtl/reply_distributor_chk.sv
module reply_distributor_chk #(
  parameter int N_CH = 4,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wr_done,
  input logic            busy,
  input logic            overflow,
  input logic [CW-1:0]   resp_count,
  input logic [N_CH-1:0] ch_valid,
  input logic [N_CH-1:0] ch_bit,
  input logic [N_CH-1:0] ch_stb,
  input logic            tx_done
);
  p_overflow_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> overflow);

  p_start_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_done));

  p_stb_only_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (ch_stb & ~ch_valid) == '0);

  p_bit_under_stb_r5: assert property (@(posedge clk) disable iff (rst)
    (ch_bit & ~ch_stb) == '0);

  p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ch_stb == '0));

  p_count_match_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ($countones(ch_valid) == int'(resp_count)));

  p_done_outside_busy_r8: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
endmodule

bind reply_distributor reply_distributor_chk #(.N_CH(N_CH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_done   (wr_done),
  .busy      (busy),
  .overflow  (overflow),
  .resp_count(resp_count),
  .ch_valid  (ch_valid),
  .ch_bit    (ch_bit),
  .ch_stb    (ch_stb),
  .tx_done   (tx_done)
);

// File: tb/reply_distributor_bench.sv
module reply_distributor_bench;
  localparam int N_CH = 4;
  localparam int DS   = 6;
  localparam int DF   = 3;
  localparam int CW   = $clog2(N_CH + 1);
  localparam int NSC  = 4;
  // Table: words written, rate select, expected responder count.
  localparam int SC_WORDS [NSC] = '{8, 5, 2, 0};
  localparam int SC_RATE  [NSC] = '{0, 1, 0, 1};
  localparam int SC_CNT   [NSC] = '{4, 2, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_done = 1'b0;
  logic rate_sel = 1'b0;
  logic busy, overflow, tx_done;
  logic [CW-1:0] resp_count;
  logic [N_CH-1:0] ch_valid, ch_bit, ch_stb;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  logic [31:0] wbuf [16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reply_distributor #(.N_CH(N_CH), .WORD_W(32), .DIV_SLOW(DS), .DIV_FAST(DF))
    u_reply_distributor (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_done(wr_done),
      .rate_sel(rate_sel), .busy(busy), .overflow(overflow),
      .resp_count(resp_count), .ch_valid(ch_valid), .ch_bit(ch_bit),
      .ch_stb(ch_stb), .tx_done(tx_done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_err++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  task automatic write_word(input logic [31:0] d, output logic of);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk); of = overflow;
  endtask

  // nw words from wbuf; mid: write during busy; dw: write with wr_done.
  task automatic run_batch(input int nw, input logic rs, input int exp_cnt,
                           input bit mid, input bit dw);
    logic of;
    logic [63:0] got [N_CH];
    int cnt [N_CH];
    int last_stb, gap_err, t0, div, done_seen, done_cyc;
    for (int i = 0; i < nw; i++) begin
      write_word(wbuf[i], of);
      chk(of == (i >= 2 * N_CH), "R3 store-full write flag", of, i >= 2 * N_CH);
    end
    @(posedge clk); #1 wr_done = 1'b1; rate_sel = rs;
    if (dw) begin wr_en = 1'b1; wr_data = 32'hDEAD_BEEF; end
    @(posedge clk); #1 wr_done = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy after wr_done", busy, 1);
    if (dw) chk(overflow == 1'b1, "R3 write with wr_done flagged", overflow, 1);
    for (int k = 0; k < N_CH; k++) begin got[k] = '0; cnt[k] = 0; end
    last_stb = -1; gap_err = 0; t0 = 0; done_seen = 0; done_cyc = 0;
    div = rs ? DF : DS;
    while (!done_seen && t0 < 2000) begin
      if (mid && t0 == 10) wr_en = 1'b1;
      if (mid && t0 == 11) begin
        chk(overflow == 1'b1, "R3 busy write flagged", overflow, 1);
        wr_en = 1'b0;
      end
      if (ch_stb != '0) begin
        if (last_stb >= 0 && (t0 - last_stb) != div) gap_err++;
        last_stb = t0;
      end
      for (int k = 0; k < N_CH; k++)
        if (ch_stb[k]) begin
          if (cnt[k] < 64) got[k][cnt[k]] = ch_bit[k];
          cnt[k]++;
        end
      if (tx_done) begin done_seen = 1; done_cyc = t0; end
      else begin @(negedge clk); t0++; end
    end
    chk(done_seen == 1, "R8 tx_done seen", done_seen, 1);
    chk(busy == 1'b0, "R8 busy low with tx_done", busy, 0);
    if (last_stb >= 0)
      chk(done_cyc - last_stb == 1, "R8 done one cycle after last strobe", done_cyc - last_stb, 1);
    else
      chk(done_cyc == 1, "R8 zero-pair done timing", done_cyc, 1);
    chk(gap_err == 0, "R6 strobe spacing", gap_err, 0);
    chk(int'(resp_count) == exp_cnt, "R7 responder count", resp_count, exp_cnt);
    chk(ch_valid == N_CH'((1 << exp_cnt) - 1), "R7 valid mask", ch_valid, (1 << exp_cnt) - 1);
    for (int k = 0; k < N_CH; k++) begin
      if (k < exp_cnt) begin
        chk(cnt[k] == 64, "R5 bit count", cnt[k], 64);
        chk(got[k] == {wbuf[2*k+1], wbuf[2*k]}, "R2 channel data LSB first",
            got[k], {wbuf[2*k+1], wbuf[2*k]});
      end else begin
        chk(cnt[k] == 0, "R5 empty channel silent", cnt[k], 0);
      end
    end
    @(negedge clk);
    chk(tx_done == 1'b0, "R8 tx_done single cycle", tx_done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({busy, overflow, tx_done} == 3'b000, "R1 control outputs", {busy, overflow, tx_done}, 0);
    chk(resp_count == '0 && ch_valid == '0, "R1 count and valid", {resp_count, ch_valid}, 0);
    chk(ch_stb == '0 && ch_bit == '0, "R1 serial outputs", {ch_stb, ch_bit}, 0);

    // Table-driven batches
    for (int s = 0; s < NSC; s++) begin
      for (int i = 0; i < 16; i++)
        wbuf[i] = (s == 2 && i == 1) ? 32'h0 :
                  {4'hA, 4'(s), 8'(i), 16'h3C5A ^ 16'(i * 777 + s * 31)};
      run_batch(SC_WORDS[s], SC_RATE[s][0], SC_CNT[s], 1'b0, 1'b0);
    end

    // R3: write while busy is ignored; next batch restarts at slot 0 (R2)
    for (int i = 0; i < 16; i++) wbuf[i] = 32'h1111_0000 + 32'(i * 3);
    wr_data = 32'hBAD0_BAD0;
    run_batch(2, 1'b1, 1, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) wbuf[i] = 32'h5A5A_0000 ^ 32'(i * 97);
    run_batch(2, 1'b1, 1, 1'b0, 1'b0);

    // R3: ninth word into a full store is ignored
    for (int i = 0; i < 16; i++) wbuf[i] = 32'hC0DE_0000 + 32'(i);
    run_batch(9, 1'b1, 4, 1'b0, 1'b0);

    // R3: write in the same cycle as wr_done is ignored
    for (int i = 0; i < 16; i++) wbuf[i] = 32'h7700_0000 | 32'(i << 4);
    run_batch(4, 1'b0, 2, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule